// File: doc/BRIEF.md
# Multi-Port Receive Distributor with Sync-Period Error Flags

This block sits behind a point-to-point link receiver. Each beat from the link carries four things: a destination port index, a 32-bit word, and start-of-frame and end-of-frame flags. The block steers each beat into a small FIFO owned by the addressed port. Each port then releases its words as soon as they are available, in asynchronous fashion, on a 33-bit output lane. Bits 31:0 of a lane carry the word and bit 32 pulses high for one cycle to mark it.

Downstream logic takes at most one word from a port every `RELEASE_GAP` cycles. A burst aimed at one port therefore piles up in that port's FIFO. When the FIFO is full, the link stream is stalled through a ready signal. Three sticky flags report problems:

- a beat that met a full FIFO;
- a sync pulse that arrived while any FIFO still held undelivered words;
- a beat addressed to a port that is not implemented.

Frame flags travel with the words of 1 to 4 ports only. Those ports sit at either the top or the bottom of the active port range.

Top module: `sync_rx_distributor`

## Requirements
- R1: After reset, `in_ready_o` is 1, every lane's bit 32 is 0, `sof_o`/`eof_o` are 0, and the three error flags are 0.
- R2: A beat accepted at clock edge t, addressed to an empty port p < `N_PORTS` whose pacing has expired, appears on lane p (`port_o[p*33 +: 33]`) after edge t+1. Its bit 32 is high for exactly one cycle and bits 31:0 equal the word. Each port delivers its words in arrival order, and none is lost or duplicated.
- R3: Two successive words on the same lane are at least `RELEASE_GAP` cycles apart. Each port FIFO holds up to `FIFO_DEPTH` words.
- R4: `in_ready_o` is 0 exactly when `in_valid_i` is 1 and the FIFO of the addressed in-range port holds `FIFO_DEPTH` words. A beat seen with `in_ready_o` = 0 is not taken.
- R5: `rx_overflow_o` is set at the edge that ends a cycle in which a valid beat met a full FIFO. It then stays 1 until reset.
- R6: `rx_overrun_o` is set at the edge that ends a cycle in which `sync_i` was 1 while any port FIFO held at least one word. It stays 1 until reset. A sync pulse with all FIFOs empty leaves it at 0.
- R7: A beat whose index is ≥ `N_PORTS` is always accepted and dropped, and no lane shows it. `bad_port_o` is set at the following edge and stays 1 until reset.
- R8: Frame ports are `FRM_PORTS` in number. With `FRM_UPPER` = 1 they are ports `N_PORTS-FRM_PORTS+k`; otherwise they are ports `k`. `sof_o[k]`/`eof_o[k]` pulse together with that port's bit 32 and carry the flags sent with the word. Flags sent to any other port are discarded, and `sof_o`/`eof_o` are 0 whenever their port shows no word.
- R9: A full FIFO on one port does not stall beats addressed to another port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Beat present on the link stream |
| in_ready_o | output | 1 | Beat taken at this edge when high |
| in_port_i | input | PORT_W | Destination port index |
| in_data_i | input | 32 | Data word |
| in_sof_i | input | 1 | Start-of-frame flag of the beat |
| in_eof_i | input | 1 | End-of-frame flag of the beat |
| sync_i | input | 1 | Synchronization period pulse |
| port_o | output | N_PORTS*33 | Output lanes: per port {valid, data[31:0]} |
| sof_o | output | FRM_PORTS | Start-of-frame pulse per frame port |
| eof_o | output | FRM_PORTS | End-of-frame pulse per frame port |
| rx_overflow_o | output | 1 | Sticky: a beat met a full FIFO |
| rx_overrun_o | output | 1 | Sticky: sync arrived with words still buffered |
| bad_port_o | output | 1 | Sticky: a beat named an unimplemented port |

## Verification
A corrupted FIFO count or pointer shows up in one of three ways: a wrong `in_ready_o` in the very cycle the beat is offered, or a word on a lane that differs from the arrival-order model, or a lane pulse with nothing queued. Each of these is visible within `FIFO_DEPTH * RELEASE_GAP` cycles of the fault. A broken pacing counter shows up as two pulses closer than `RELEASE_GAP` on one lane. Errors in the sticky flags are visible one cycle after the condition that should set them, and the bench compares all three flags every cycle.

// File: rtl/sync_rx_pkg.sv
`timescale 1ns/1ps
package sync_rx_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LANE_W = DATA_W + 1;

  typedef struct packed {
    logic              sof;
    logic              eof;
    logic [DATA_W-1:0] data;
  } rx_word_t;

  // frame ports sit at the top or bottom of the active range
  function automatic logic is_frame_port(int unsigned p, int unsigned n,
                                         int unsigned f, logic upper);
    return upper ? (p + f >= n) : (p < f);
  endfunction
endpackage

// File: rtl/sync_rx_route.sv
`timescale 1ns/1ps
module sync_rx_route #(
  parameter int unsigned N_PORTS = 4,
  parameter int unsigned PORT_W  = 5
) (
  input  logic              in_valid_i,
  input  logic [PORT_W-1:0] in_port_i,
  input  logic [N_PORTS-1:0] full_i,
  output logic [N_PORTS-1:0] push_o,
  output logic              ready_o,
  output logic              bad_o,
  output logic              blocked_o
);
  logic [N_PORTS-1:0] hit;
  logic in_range;
  logic target_full;

  for (genvar p = 0; p < N_PORTS; p++) begin : g_hit
    assign hit[p] = (in_port_i == PORT_W'(p));
  end

  assign in_range    = 32'(in_port_i) < N_PORTS;
  assign target_full = |(hit & full_i);
  assign push_o      = hit & ~full_i & {N_PORTS{in_valid_i}};
  assign ready_o     = !(in_valid_i && in_range && target_full);
  assign blocked_o   = in_valid_i && in_range && target_full;
  assign bad_o       = in_valid_i && !in_range;
endmodule

// File: rtl/sync_rx_port_fifo.sv
`timescale 1ns/1ps
module sync_rx_port_fifo import sync_rx_pkg::*; #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned GAP   = 3
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     push_i,
  input  rx_word_t wdata_i,
  output logic     full_o,
  output logic     empty_o,
  output logic     out_valid_o,
  output rx_word_t out_word_o
);
  localparam int unsigned PTR_W = DEPTH > 1 ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned GAP_W = GAP > 1 ? $clog2(GAP) : 1;
  localparam logic [PTR_W-1:0] LAST     = PTR_W'(DEPTH - 1);
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(GAP - 1);

  rx_word_t          mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [GAP_W-1:0]  gap_q;
  logic              pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign pop     = !empty_o && (gap_q == '0);

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop)    rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop);
    end
  end

  // downstream pacing: one release per GAP cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          gap_q <= '0;
    else if (pop)         gap_q <= GAP_LOAD;
    else if (gap_q != '0) gap_q <= gap_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_word_o  <= '0;
    end else begin
      out_valid_o <= pop;
      if (pop) out_word_o <= mem_q[rd_q];
    end
  end
endmodule

// File: rtl/sync_rx_distributor.sv
`timescale 1ns/1ps
module sync_rx_distributor import sync_rx_pkg::*; #(
  parameter int unsigned N_PORTS     = 4,
  parameter int unsigned FIFO_DEPTH  = 4,
  parameter int unsigned RELEASE_GAP = 3,
  parameter int unsigned FRM_PORTS   = 2,
  parameter bit          FRM_UPPER   = 1'b1,
  parameter int unsigned PORT_W      = 5
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      in_valid_i,
  output logic                      in_ready_o,
  input  logic [PORT_W-1:0]         in_port_i,
  input  logic [DATA_W-1:0]         in_data_i,
  input  logic                      in_sof_i,
  input  logic                      in_eof_i,
  input  logic                      sync_i,
  output logic [N_PORTS*LANE_W-1:0] port_o,
  output logic [FRM_PORTS-1:0]      sof_o,
  output logic [FRM_PORTS-1:0]      eof_o,
  output logic                      rx_overflow_o,
  output logic                      rx_overrun_o,
  output logic                      bad_port_o
);
  logic [N_PORTS-1:0] push_v, full_v, empty_v, out_valid, out_sof, out_eof;
  rx_word_t           out_word [N_PORTS];
  logic               bad_hit, blocked;

  sync_rx_route #(.N_PORTS(N_PORTS), .PORT_W(PORT_W)) u_route (
    .in_valid_i (in_valid_i),
    .in_port_i  (in_port_i),
    .full_i     (full_v),
    .push_o     (push_v),
    .ready_o    (in_ready_o),
    .bad_o      (bad_hit),
    .blocked_o  (blocked)
  );

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    localparam bit IS_FRM = is_frame_port(p, N_PORTS, FRM_PORTS, FRM_UPPER);
    rx_word_t wr_word;

    // flags survive only on frame ports
    assign wr_word.sof  = in_sof_i & IS_FRM;
    assign wr_word.eof  = in_eof_i & IS_FRM;
    assign wr_word.data = in_data_i;

    sync_rx_port_fifo #(.DEPTH(FIFO_DEPTH), .GAP(RELEASE_GAP)) u_fifo (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .push_i      (push_v[p]),
      .wdata_i     (wr_word),
      .full_o      (full_v[p]),
      .empty_o     (empty_v[p]),
      .out_valid_o (out_valid[p]),
      .out_word_o  (out_word[p])
    );

    assign port_o[p*LANE_W +: LANE_W] = {out_valid[p], out_word[p].data};
    assign out_sof[p] = out_valid[p] & out_word[p].sof;
    assign out_eof[p] = out_valid[p] & out_word[p].eof;
  end

  for (genvar k = 0; k < FRM_PORTS; k++) begin : g_frm
    localparam int unsigned FP = FRM_UPPER ? N_PORTS - FRM_PORTS + k : k;
    localparam logic [N_PORTS-1:0] SEL = N_PORTS'(1) << FP;
    assign sof_o[k] = |(out_sof & SEL);
    assign eof_o[k] = |(out_eof & SEL);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_overflow_o <= 1'b0;
      rx_overrun_o  <= 1'b0;
      bad_port_o    <= 1'b0;
    end else begin
      if (blocked)                 rx_overflow_o <= 1'b1;
      if (sync_i && !(&empty_v))   rx_overrun_o  <= 1'b1;
      if (bad_hit)                 bad_port_o    <= 1'b1;
    end
  end
endmodule

// File: rtl/sync_rx_distributor_chk.sv
`timescale 1ns/1ps
module sync_rx_distributor_chk #(
  parameter int unsigned N_PORTS     = 4,
  parameter int unsigned PORT_W      = 5,
  parameter int unsigned RELEASE_GAP = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               in_valid_i,
  input logic               in_ready_i,
  input logic [PORT_W-1:0]  in_port_i,
  input logic               sync_i,
  input logic [N_PORTS-1:0] port_valid_i,
  input logic [N_PORTS-1:0] empty_i,
  input logic [N_PORTS-1:0] full_i,
  input logic               overflow_i,
  input logic               overrun_i,
  input logic               bad_port_i
);
  p_ready_low_needs_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_i |-> (in_valid_i && |full_i));

  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !in_ready_i) |=> overflow_i);

  p_overflow_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_i |=> overflow_i);

  p_overrun_on_busy_sync_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i && !(&empty_i)) |=> overrun_i);

  p_overrun_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_i |=> overrun_i);

  p_bad_port_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && (32'(in_port_i) >= N_PORTS)) |=> bad_port_i);

  p_bad_port_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_port_i |=> bad_port_i);

  for (genvar p = 0; p < N_PORTS; p++) begin : g_lane
    p_word_from_fifo_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(port_valid_i[p]) |-> $past(!empty_i[p]));
    if (RELEASE_GAP > 1) begin : g_gap
      p_pacing_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        port_valid_i[p] |=> !port_valid_i[p]);
    end
  end
endmodule

bind sync_rx_distributor sync_rx_distributor_chk #(
  .N_PORTS(N_PORTS), .PORT_W(PORT_W), .RELEASE_GAP(RELEASE_GAP)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_valid_i   (in_valid_i),
  .in_ready_i   (in_ready_o),
  .in_port_i    (in_port_i),
  .sync_i       (sync_i),
  .port_valid_i (out_valid),
  .empty_i      (empty_v),
  .full_i       (full_v),
  .overflow_i   (rx_overflow_o),
  .overrun_i    (rx_overrun_o),
  .bad_port_i   (bad_port_o)
);

// File: tb/sync_rx_distributor_bench.sv
`timescale 1ns/1ps
module sync_rx_distributor_bench;
  import sync_rx_pkg::*;
  localparam int N  = 4;
  localparam int D  = 4;
  localparam int G  = 3;
  localparam int F  = 2;
  localparam int PW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic in_valid = 0, in_sof = 0, in_eof = 0, sync = 0;
  logic [PW-1:0] in_port = '0;
  logic [31:0] in_data = '0;
  logic in_ready, ovf, ovr, bad;
  logic [N*LANE_W-1:0] lanes;
  logic [F-1:0] sof, eof;

  sync_rx_distributor #(.N_PORTS(N), .FIFO_DEPTH(D), .RELEASE_GAP(G),
    .FRM_PORTS(F), .FRM_UPPER(1'b1), .PORT_W(PW)) u_sync_rx_distributor (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_port_i(in_port), .in_data_i(in_data), .in_sof_i(in_sof), .in_eof_i(in_eof),
    .sync_i(sync), .port_o(lanes), .sof_o(sof), .eof_o(eof),
    .rx_overflow_o(ovf), .rx_overrun_o(ovr), .bad_port_o(bad));

  int checks = 0, fails = 0, cyc = 0;
  logic [33:0] exp_q [N][$];
  int m_cnt [N];
  int last_out [N];
  bit m_ovf = 0, m_ovr = 0, m_bad = 0;

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit lane_v(int p);
    return lanes[p*LANE_W + DATA_W];
  endfunction

  function automatic logic [31:0] lane_d(int p);
    return lanes[p*LANE_W +: DATA_W];
  endfunction

  task automatic step(input bit v, input int pt, input logic [31:0] d,
                      input bit s, input bit e, input bit sy, output bit acc);
    bit exp_rdy, rng, ovf_c, ovr_c;
    logic [33:0] item;
    in_valid = v; in_port = PW'(pt); in_data = d; in_sof = s; in_eof = e; sync = sy;
    #1;
    rng = pt < N;
    exp_rdy = !(v && rng && (m_cnt[pt] == D));
    check(in_ready == exp_rdy, "R4 ready", 64'(in_ready), 64'(exp_rdy));
    acc = v && in_ready;
    ovf_c = v && rng && !exp_rdy;
    ovr_c = 0;
    for (int p = 0; p < N; p++) if (m_cnt[p] > 0) ovr_c = 1;
    ovr_c = ovr_c && sy;
    @(posedge clk);
    @(negedge clk);
    cyc++;
    for (int p = 0; p < N; p++) begin
      if (lane_v(p)) begin
        if (exp_q[p].size() == 0) begin
          check(0, "R2/R7 unexpected word", 64'(lane_d(p)), 64'(p));
        end else begin
          item = exp_q[p].pop_front();
          check(lane_d(p) == item[31:0], "R2 data", 64'(lane_d(p)), 64'(item[31:0]));
          if (p >= N - F) begin
            check({sof[p-(N-F)], eof[p-(N-F)]} == item[33:32], "R8 flags",
                  64'({sof[p-(N-F)], eof[p-(N-F)]}), 64'(item[33:32]));
          end
          m_cnt[p]--;
        end
        check(cyc - last_out[p] >= G, "R3 pacing", 64'(cyc - last_out[p]), 64'(G));
        last_out[p] = cyc;
      end
    end
    for (int k = 0; k < F; k++)
      if (!lane_v(N - F + k))
        check(!sof[k] && !eof[k], "R8 idle flags", 64'({sof[k], eof[k]}), 64'(0));
    if (acc && rng) begin
      exp_q[pt].push_back({s, e, d});
      m_cnt[pt]++;
    end
    if (ovf_c) m_ovf = 1;
    if (ovr_c) m_ovr = 1;
    if (v && !rng) m_bad = 1;
    check(ovf == m_ovf, "R5 overflow", 64'(ovf), 64'(m_ovf));
    check(ovr == m_ovr, "R6 overrun", 64'(ovr), 64'(m_ovr));
    check(bad == m_bad, "R7 bad port", 64'(bad), 64'(m_bad));
  endtask

  task automatic idle(int n);
    bit a;
    for (int i = 0; i < n; i++) step(0, 0, 32'h0, 0, 0, 0, a);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
    summary();
    $finish;
  end

  initial begin
    bit a;
    int stalls;
    for (int p = 0; p < N; p++) begin m_cnt[p] = 0; last_out[p] = -100; end
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(in_ready == 1, "R1 ready", 64'(in_ready), 64'(1));
    for (int p = 0; p < N; p++) check(!lane_v(p), "R1 lane idle", 64'(lane_v(p)), 64'(0));
    check({sof, eof} == '0, "R1 frame flags", 64'({sof, eof}), 64'(0));
    check({ovf, ovr, bad} == 3'b0, "R1 error flags", 64'({ovf, ovr, bad}), 64'(0));
    rst_n = 1;
    @(negedge clk);

    // R6 sync with empty FIFOs leaves overrun clear
    step(0, 0, 0, 0, 0, 1, a);
    check(ovr == 0, "R6 idle sync", 64'(ovr), 64'(0));

    // R2 latency: accepted at edge t, visible after t+1 for one cycle
    step(1, 0, 32'hA5A5_0001, 0, 0, 0, a);
    check(!lane_v(0), "R2 not before t+1", 64'(lane_v(0)), 64'(0));
    step(0, 0, 0, 0, 0, 0, a);
    check(lane_v(0) && lane_d(0) == 32'hA5A5_0001, "R2 at t+1",
          64'(lane_d(0)), 64'(32'hA5A5_0001));
    step(0, 0, 0, 0, 0, 0, a);
    check(!lane_v(0), "R2 one-cycle pulse", 64'(lane_v(0)), 64'(0));

    // R7 unimplemented port
    step(1, 5, 32'hDEAD_BEEF, 0, 0, 0, a);
    check(a == 1, "R7 accepted", 64'(a), 64'(1));
    idle(4);
    check(bad == 1, "R7 sticky", 64'(bad), 64'(1));

    // R8 frame port and non-frame port
    step(1, 2, 32'h0000_0B0B, 1, 0, 0, a);
    step(1, 0, 32'h0000_0C0C, 1, 1, 0, a);
    step(1, 3, 32'h0000_0D0D, 0, 1, 0, a);
    idle(6);

    // R4/R5 burst to port 1 until full, then R9 on port 0
    stalls = 0;
    for (int i = 0; i < 7; i++) begin
      step(1, 1, 32'h1000 + i, 0, 0, 0, a);
      while (!a) begin stalls++; step(1, 1, 32'h1000 + i, 0, 0, 0, a); end
    end
    check(stalls > 0, "R4 stall seen", 64'(stalls), 64'(1));
    check(ovf == 1, "R5 overflow set", 64'(ovf), 64'(1));
    step(1, 0, 32'h0000_9999, 0, 0, 0, a);
    check(a == 1, "R9 other port free", 64'(a), 64'(1));
    idle(30);

    // R6 sync while a word waits
    step(1, 3, 32'h0000_3333, 0, 0, 0, a);
    step(0, 0, 0, 0, 0, 1, a);
    check(ovr == 1, "R6 busy sync", 64'(ovr), 64'(1));
    idle(5);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      bit v, s, e, sy;
      int pt;
      v  = ($urandom % 10) < 7;
      pt = $urandom % 6;
      s  = $urandom % 2;
      e  = $urandom % 2;
      sy = ($urandom % 40) == 0;
      step(v, pt, $urandom, s, e, sy, a);
    end
    idle(40);
    for (int p = 0; p < N; p++)
      check(exp_q[p].size() == 0, "R2 all delivered", 64'(exp_q[p].size()), 64'(0));

    summary();
    $finish;
  end
endmodule